// File: doc/BRIEF.md
# Exception-Level Entry and Vector Unit

This block handles the transfer of control between an unprivileged level 0 and a privileged level 1 in a processor core. It takes the core's exception requests: a synchronous fault from the current instruction, a supervisor call carrying a 16-bit immediate, an exception-return instruction, and three asynchronous sources (system error, fast interrupt, normal interrupt). It picks one request and works out the handler address from a programmable vector base. It then saves the return address, the old processor-state word and a cause value into level-1 registers, and switches the active stack-pointer bank. The block owns the processor-state word. An exception return at level 1 restores that word and the PC from the saved registers.

The control is a three-state machine. `RUN` accepts requests and privileged register writes. The transition *take* goes from `RUN` to `ENTER`, and the transition *return* goes from `RUN` to `LEAVE`. Both `ENTER` and `LEAVE` go back to `RUN` through *finish* after one cycle. In `ENTER` or `LEAVE` the redirect output is valid and the saved registers are written at the end of the cycle.

The processor-state word uses these bits:

| Bits | Meaning |
|---|---|
| [0] | Stack select (1 = level's own SP) |
| [3:2] | Level (only 0 and 1 are used) |
| [6] | Fast-interrupt mask |
| [7] | Normal-interrupt mask |

All other bits pass through unchanged.

Top module: `el_trap_unit`

## Requirements
- R1: After reset the state word is 0x000000C5, meaning level 1, own SP, both interrupt masks set. In the same state `redirect_valid` is 0, and the link, saved-state and cause registers read 0.
- R2: The handler address is computed as follows:
  - Start from the vector base with its low 11 bits forced to zero. The base is written with `rw_sel`=0.
  - Add the group: 0x000 for level 1 with SP0, 0x200 for level 1 with its own SP, and 0x400 for an exception taken from level 0.
  - Add the class: 0x000 for synchronous, 0x080 for normal interrupt, 0x100 for fast interrupt, 0x180 for system error.
- R3: When several requests are present, the block takes the first of this order: synchronous fault, supervisor call, exception return, system error, fast interrupt, normal interrupt.
- R4: A normal interrupt is not taken while state bit 7 is set, and a fast interrupt is not taken while bit 6 is set. System error is never masked.
- R5: On entry the return address goes to the link register:
  - `cur_pc`+4 for a supervisor call.
  - `cur_pc` for every other entry.
  
  The old state word goes to the saved-state register. The new state has level 1, bit 0 set, bits 7 and 6 set, and all other bits kept.
- R6: The cause register is written as follows:
  - A synchronous fault loads `sync_syndrome`.
  - A supervisor call loads 0x15 in bits [31:26] and the immediate in bits [15:0], with all other bits zero.
  - Interrupts and system error leave the cause register unchanged.
- R7: An exception return at level 1 redirects to the link register and loads the state word from the saved-state register.
- R8: An exception return at level 0 is taken as a synchronous exception instead. It uses cause 0, link = `cur_pc`, and the level-0 vector offset 0x400.
- R9: `sp_active` reads the level-1 bank when state bits [2] and [0] are both set, and the level-0 bank otherwise. `sp_wr_en` writes only the active bank. A change of level or stack select switches banks without altering either bank's contents.
- R10: Writes through `rw_en` change nothing while the block is at level 0. The selector values are 0 for base, 1 for link and 2 for saved state.
- R11: An accepted request raises `redirect_valid` for exactly one cycle, starting the cycle after acceptance. A request still present during that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req | input | 1 | Synchronous fault from the current instruction |
| sync_syndrome | input | 32 | Cause value for a synchronous fault |
| svc_req | input | 1 | Supervisor call request |
| svc_imm | input | 16 | Supervisor call immediate |
| eret_req | input | 1 | Exception-return instruction |
| serr_req | input | 1 | System error request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| cur_pc | input | 64 | PC of the current instruction |
| rw_en | input | 1 | Privileged register write strobe |
| rw_sel | input | 2 | 0 base, 1 link, 2 saved state |
| rw_data | input | 64 | Register write data |
| sp_wr_en | input | 1 | Write the active stack pointer |
| sp_wr_data | input | 64 | Stack pointer write data |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | 64 | Redirect target |
| state_o | output | 32 | Current processor-state word |
| link_o | output | 64 | Return-address register |
| saved_o | output | 32 | Saved-state register |
| cause_o | output | 32 | Cause register |
| sp_active | output | 64 | Active stack pointer |
| busy | output | 1 | Block is in ENTER or LEAVE |

## Verification
The assertions assume that the level field of every state word loaded through the saved-state register is 0 or 1, because bit 3 is never given a meaning. They also assume that requests are dropped once `redirect_valid` has been seen. The stimulus only writes saved-state values with bit 3 clear. It releases each request at the falling edge after acceptance, except in the one case that deliberately holds a request through `ENTER` to show that it is not taken twice. Interrupt requests are level inputs, so the masked-interrupt case holds them for several cycles and watches that neither the redirect nor the state word moves.

// File: rtl/el_trap_pkg.sv
package el_trap_pkg;

    // Vector geometry: entry spacing and full table span as log2
    localparam int VEC_ENT_LG  = 7;
    localparam int VEC_SPAN_LG = VEC_ENT_LG + 4;

    // Processor-state word bit positions
    localparam int SB_SPSEL  = 0;
    localparam int SB_LVL_LO = 2;
    localparam int SB_LVL_HI = 3;
    localparam int SB_FMASK  = 6;
    localparam int SB_IMASK  = 7;

    localparam logic [5:0]  SVC_CLASS = 6'h15;
    localparam logic [31:0] RST_STATE = 32'h0000_00C5;

    typedef enum logic [1:0] {
        CLS_SYNC = 2'd0,
        CLS_IRQ  = 2'd1,
        CLS_FIQ  = 2'd2,
        CLS_SERR = 2'd3
    } exc_class_e;

    typedef enum logic [1:0] {
        GRP_CUR_SP0 = 2'd0,
        GRP_CUR_SPX = 2'd1,
        GRP_LOWER   = 2'd2
    } vec_group_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SYNC,
        SRC_SVC,
        SRC_UNDEF,
        SRC_RET,
        SRC_SERR,
        SRC_FIQ,
        SRC_IRQ
    } src_e;

    typedef enum logic [1:0] {
        FSM_RUN,
        FSM_ENTER,
        FSM_LEAVE
    } fsm_e;

    typedef enum logic [1:0] {
        RW_BASE  = 2'd0,
        RW_LINK  = 2'd1,
        RW_SAVED = 2'd2
    } rw_sel_e;

endpackage

// File: rtl/el_trap_arb.sv
module el_trap_arb
    import el_trap_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic svc_req,
    input  logic eret_req,
    input  logic serr_req,
    input  logic fiq_req,
    input  logic irq_req,
    input  logic lvl,
    input  logic imask,
    input  logic fmask,
    output src_e src
);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] gnt;

    always_comb begin
        logic seen;
        req  = {irq_req & ~imask, fiq_req & ~fmask, serr_req,
                eret_req, svc_req, sync_req};
        seen = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            gnt[i] = req[i] & ~seen;
            seen   = seen | req[i];
        end
    end

    always_comb begin
        src = SRC_NONE;
        if (gnt[0]) src = SRC_SYNC;
        if (gnt[1]) src = SRC_SVC;
        if (gnt[2]) src = lvl ? SRC_RET : SRC_UNDEF;
        if (gnt[3]) src = SRC_SERR;
        if (gnt[4]) src = SRC_FIQ;
        if (gnt[5]) src = SRC_IRQ;
    end

    // R3: at most one source is granted
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4: a masked normal interrupt never wins
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (imask && !(sync_req | svc_req | eret_req | serr_req | fiq_req)) |-> (src == SRC_NONE));

endmodule

// File: rtl/el_trap_vec.sv
module el_trap_vec
    import el_trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-VEC_SPAN_LG-1:0] base_hi,
    input  vec_group_e                  grp,
    input  exc_class_e                  cls,
    output logic [XLEN-1:0]             vaddr
);

    always_comb begin
        vaddr = {base_hi, grp, cls, {VEC_ENT_LG{1'b0}}};
    end

endmodule

// File: rtl/el_trap_spbank.sv
module el_trap_spbank #(
    parameter int XLEN  = 64,
    parameter int NBANK = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_hi,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] bank_q [NBANK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) bank_q[b] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBANK; b++) begin
                if (b == int'(sel_hi)) bank_q[b] <= wr_data;
            end
        end
    end

    always_comb rd_data = bank_q[sel_hi];

    // R9: a write to one bank leaves the other untouched
    assert_bank0_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_hi) |=> $stable(bank_q[0]));
    assert_bank1_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_hi) |=> $stable(bank_q[1]));

endmodule

// File: rtl/el_trap_unit.sv
module el_trap_unit
    import el_trap_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int SYN_W      = 32,
    parameter int ST_W       = 32,
    parameter int IMM_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_req,
    input  logic [SYN_W-1:0] sync_syndrome,
    input  logic             svc_req,
    input  logic [IMM_W-1:0] svc_imm,
    input  logic             eret_req,
    input  logic             serr_req,
    input  logic             fiq_req,
    input  logic             irq_req,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             rw_en,
    input  logic [1:0]       rw_sel,
    input  logic [XLEN-1:0]  rw_data,
    input  logic             sp_wr_en,
    input  logic [XLEN-1:0]  sp_wr_data,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [ST_W-1:0]  state_o,
    output logic [XLEN-1:0]  link_o,
    output logic [ST_W-1:0]  saved_o,
    output logic [SYN_W-1:0] cause_o,
    output logic [XLEN-1:0]  sp_active,
    output logic             busy
);

    localparam int BHI_W = XLEN - VEC_SPAN_LG;

    fsm_e             fsm_q, fsm_d;
    logic [ST_W-1:0]  pstate_q, saved_q, entry_st;
    logic [XLEN-1:0]  link_q, tgt_q, link_nxt_q, vaddr;
    logic [SYN_W-1:0] cause_q, cause_nxt_q, svc_syn;
    logic             cause_upd_q;
    logic [BHI_W-1:0] base_hi_q;
    src_e             src;
    exc_class_e       cls;
    vec_group_e       grp;
    logic             in_run, lvl, take_exc, take_ret, priv_wr;

    assign in_run = (fsm_q == FSM_RUN);
    assign lvl    = pstate_q[SB_LVL_LO];

    el_trap_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req & in_run),
        .svc_req  (svc_req  & in_run),
        .eret_req (eret_req & in_run),
        .serr_req (serr_req & in_run),
        .fiq_req  (fiq_req  & in_run),
        .irq_req  (irq_req  & in_run),
        .lvl      (lvl),
        .imask    (pstate_q[SB_IMASK]),
        .fmask    (pstate_q[SB_FMASK]),
        .src      (src)
    );

    always_comb begin
        if (!lvl)                       grp = GRP_LOWER;
        else if (pstate_q[SB_SPSEL])    grp = GRP_CUR_SPX;
        else                            grp = GRP_CUR_SP0;
        unique case (src)
            SRC_SERR: cls = CLS_SERR;
            SRC_FIQ:  cls = CLS_FIQ;
            SRC_IRQ:  cls = CLS_IRQ;
            default:  cls = CLS_SYNC;
        endcase
        take_ret = (src == SRC_RET);
        take_exc = (src != SRC_NONE) && !take_ret;
        priv_wr  = rw_en && in_run && lvl && !take_exc && !take_ret;
        svc_syn  = '0;
        svc_syn[SYN_W-1 -: 6] = SVC_CLASS;
        svc_syn[IMM_W-1:0]    = svc_imm;
        entry_st = pstate_q;
        entry_st[SB_LVL_HI] = 1'b0;
        entry_st[SB_LVL_LO] = 1'b1;
        entry_st[SB_SPSEL]  = 1'b1;
        entry_st[SB_IMASK]  = 1'b1;
        entry_st[SB_FMASK]  = 1'b1;
    end

    el_trap_vec #(.XLEN(XLEN)) u_vec (
        .base_hi (base_hi_q),
        .grp     (grp),
        .cls     (cls),
        .vaddr   (vaddr)
    );

    el_trap_spbank #(.XLEN(XLEN), .NBANK(2)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_hi  (pstate_q[SB_LVL_LO] & pstate_q[SB_SPSEL]),
        .wr_en   (sp_wr_en & in_run),
        .wr_data (sp_wr_data),
        .rd_data (sp_active)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RUN;
        else        fsm_q <= fsm_d;
    end

    // Transitions: take, return, finish
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            FSM_RUN: begin
                if (take_exc)      fsm_d = FSM_ENTER;
                else if (take_ret) fsm_d = FSM_LEAVE;
            end
            FSM_ENTER: fsm_d = FSM_RUN;
            FSM_LEAVE: fsm_d = FSM_RUN;
            default:   fsm_d = FSM_RUN;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pstate_q    <= ST_W'(RST_STATE);
            saved_q     <= '0;
            link_q      <= '0;
            cause_q     <= '0;
            base_hi_q   <= '0;
            tgt_q       <= '0;
            link_nxt_q  <= '0;
            cause_nxt_q <= '0;
            cause_upd_q <= 1'b0;
        end else begin
            unique case (fsm_q)
                FSM_RUN: begin
                    if (take_exc) begin
                        tgt_q       <= vaddr;
                        link_nxt_q  <= cur_pc + ((src == SRC_SVC) ? XLEN'(INSN_BYTES) : '0);
                        cause_upd_q <= (src == SRC_SYNC) || (src == SRC_SVC) || (src == SRC_UNDEF);
                        if (src == SRC_SYNC)     cause_nxt_q <= sync_syndrome;
                        else if (src == SRC_SVC) cause_nxt_q <= svc_syn;
                        else                     cause_nxt_q <= '0;
                    end else if (take_ret) begin
                        tgt_q <= link_q;
                    end
                    if (priv_wr) begin
                        unique case (rw_sel)
                            RW_BASE:  base_hi_q <= rw_data[XLEN-1:VEC_SPAN_LG];
                            RW_LINK:  link_q    <= rw_data;
                            RW_SAVED: saved_q   <= rw_data[ST_W-1:0];
                            default:  ;
                        endcase
                    end
                end
                FSM_ENTER: begin
                    link_q   <= link_nxt_q;
                    saved_q  <= pstate_q;
                    pstate_q <= entry_st;
                    if (cause_upd_q) cause_q <= cause_nxt_q;
                end
                FSM_LEAVE: begin
                    pstate_q <= saved_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        redirect_valid = (fsm_q != FSM_RUN);
        busy           = (fsm_q != FSM_RUN);
        redirect_pc    = tgt_q;
        state_o        = pstate_q;
        link_o         = link_q;
        saved_o        = saved_q;
        cause_o        = cause_q;
    end

    // R5: entry lands at level 1 on its own SP with both masks set
    assert_entry_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_ENTER) |=> (pstate_q[SB_LVL_HI:SB_LVL_LO] == 2'b01) && pstate_q[SB_SPSEL]
                                 && pstate_q[SB_IMASK] && pstate_q[SB_FMASK]);
    assert_entry_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_ENTER) |=> (saved_q == $past(pstate_q)));
    // R7: return restores the saved word
    assert_ret_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_LEAVE) |=> (pstate_q == $past(saved_q)));
    // R11: redirect lasts one cycle
    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
    // R10: level-0 writes leave the base alone
    assert_priv_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_en && !lvl) |=> $stable(base_hi_q));
    // R2: a redirect on entry stays inside the table at the base
    assert_vec_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_ENTER) |-> (redirect_pc[XLEN-1:VEC_SPAN_LG] == base_hi_q)
                                 && (redirect_pc[VEC_ENT_LG-1:0] == '0));

endmodule

// File: tb/el_trap_unit_tb.sv
`timescale 1ns/1ps
module el_trap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_req = 0, svc_req = 0, eret_req = 0, serr_req = 0, fiq_req = 0, irq_req = 0;
    logic [31:0] sync_syndrome = '0;
    logic [15:0] svc_imm = '0;
    logic [63:0] cur_pc = '0;
    logic        rw_en = 0;
    logic [1:0]  rw_sel = '0;
    logic [63:0] rw_data = '0;
    logic        sp_wr_en = 0;
    logic [63:0] sp_wr_data = '0;
    logic        redirect_valid, busy;
    logic [63:0] redirect_pc, link_o, sp_active;
    logic [31:0] state_o, saved_o, cause_o;

    always #2.5 clk = ~clk;

    el_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .sync_req(sync_req), .sync_syndrome(sync_syndrome),
        .svc_req(svc_req), .svc_imm(svc_imm), .eret_req(eret_req),
        .serr_req(serr_req), .fiq_req(fiq_req), .irq_req(irq_req),
        .cur_pc(cur_pc), .rw_en(rw_en), .rw_sel(rw_sel), .rw_data(rw_data),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .state_o(state_o), .link_o(link_o), .saved_o(saved_o),
        .cause_o(cause_o), .sp_active(sp_active), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // request bits {sync, svc, eret, serr, fiq, irq}
    task automatic drive(input logic [5:0] r);
        {sync_req, svc_req, eret_req, serr_req, fiq_req, irq_req} = r;
    endtask

    task automatic take(input logic [5:0] r, output logic rv, output logic [63:0] rpc);
        drive(r);
        @(negedge clk);
        rv  = redirect_valid;
        rpc = redirect_pc;
        drive(6'b0);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [63:0] d);
        rw_en = 1; rw_sel = sel; rw_data = d;
        @(negedge clk);
        rw_en = 0;
    endtask

    task automatic wr_sp(input logic [63:0] d);
        sp_wr_en = 1; sp_wr_data = d;
        @(negedge clk);
        sp_wr_en = 0;
    endtask

    task automatic set_state(input logic [31:0] st);
        logic        rv;
        logic [63:0] rpc;
        if (state_o[2] == 1'b0) take(6'b000100, rv, rpc);
        wr_reg(2'd2, {32'h0, st});
        wr_reg(2'd1, 64'h4000);
        take(6'b001000, rv, rpc);
    endtask

    typedef struct packed {
        logic [31:0] st;
        logic [5:0]  rq;
        logic [11:0] off;
        logic        svc;
    } row_t;

    localparam int NROW = 12;
    localparam row_t ROWS [NROW] = '{
        '{32'h0000_0000, 6'b100000, 12'h400, 1'b0},  // lvl0 sync
        '{32'h0000_0000, 6'b010000, 12'h400, 1'b1},  // lvl0 svc
        '{32'h0000_0004, 6'b000001, 12'h080, 1'b0},  // lvl1 sp0 irq
        '{32'h0000_0005, 6'b000010, 12'h300, 1'b0},  // lvl1 spx fiq
        '{32'h0000_0000, 6'b000100, 12'h580, 1'b0},  // lvl0 serr
        '{32'h0000_0000, 6'b000111, 12'h580, 1'b0},  // serr over fiq/irq
        '{32'h0000_0000, 6'b000011, 12'h500, 1'b0},  // fiq over irq
        '{32'h0000_0005, 6'b100100, 12'h200, 1'b0},  // sync over serr
        '{32'h0000_0080, 6'b000011, 12'h500, 1'b0},  // irq masked, fiq taken
        '{32'h0000_0004, 6'b010000, 12'h000, 1'b1},  // lvl1 sp0 svc
        '{32'h0000_0045, 6'b000011, 12'h280, 1'b0},  // fiq masked, irq taken
        '{32'h2000_0000, 6'b000001, 12'h480, 1'b0}   // extra state bits kept
    };

    localparam logic [63:0] BASE_EXP = 64'h0000_0000_1234_5800;

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic        rv;
        logic [63:0] rpc;
        logic [31:0] exp_cause;
        logic [63:0] exp_link;
        exp_cause = '0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "state",  state_o, 64'hC5);
        chk("R1", "redir",  redirect_valid, 0);
        chk("R1", "link",   link_o, 0);
        chk("R1", "saved",  saved_o, 0);
        chk("R1", "cause",  cause_o, 0);

        wr_reg(2'd0, 64'h0000_0000_1234_5FFF);

        for (int i = 0; i < NROW; i++) begin
            set_state(ROWS[i].st);
            chk("R7", "restored state", state_o, ROWS[i].st);
            sync_syndrome = 32'hDEAD_0000 + i;
            svc_imm       = 16'h0100 + 16'(i);
            cur_pc        = 64'h8000 + 64'(i) * 16;
            exp_link      = cur_pc + (ROWS[i].svc ? 64'd4 : 64'd0);
            if (ROWS[i].rq[5])      exp_cause = sync_syndrome;
            else if (ROWS[i].rq[4]) exp_cause = {6'h15, 10'h0, svc_imm};
            take(ROWS[i].rq, rv, rpc);
            chk("R11", "redirect pulse", rv, 1);
            chk("R2 R3", "vector", rpc, BASE_EXP + 64'(ROWS[i].off));
            chk("R5", "link", link_o, exp_link);
            chk("R5", "saved", saved_o, ROWS[i].st);
            chk("R5", "new state", state_o, (ROWS[i].st & ~32'hD) | 32'hC5);
            chk("R6", "cause", cause_o, exp_cause);
            chk("R11", "redirect dropped", redirect_valid, 0);
        end

        // R4: masked interrupts held for several cycles are ignored
        set_state(32'h0000_00C0);
        drive(6'b000011);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4", "masked redirect", redirect_valid, 0);
        end
        drive(6'b0);
        chk("R4", "masked state", state_o, 32'hC0);

        // R8: return at level 0 is undefined
        sync_syndrome = 32'h0000_1111;
        take(6'b100000, rv, rpc);
        chk("R6", "sync cause", cause_o, 32'h1111);
        set_state(32'h0);
        cur_pc = 64'h9000;
        take(6'b001000, rv, rpc);
        chk("R8", "undef vector", rpc, BASE_EXP + 64'h400);
        chk("R8", "undef cause", cause_o, 0);
        chk("R8", "undef link", link_o, 64'h9000);
        chk("R8", "undef state", state_o, 32'hC5);

        // R7: return at level 1
        wr_reg(2'd2, 64'h84);
        wr_reg(2'd1, 64'h7770);
        take(6'b001000, rv, rpc);
        chk("R7", "return target", rpc, 64'h7770);
        chk("R7", "return state", state_o, 32'h84);

        // R9: stack banks
        wr_sp(64'h5555);
        chk("R9", "bank0 write", sp_active, 64'h5555);
        wr_reg(2'd2, 64'h5);
        take(6'b001000, rv, rpc);
        chk("R9", "bank1 fresh", sp_active, 64'h0);
        wr_sp(64'hAAAA);
        set_state(32'h0);
        chk("R9", "level0 bank", sp_active, 64'h5555);
        take(6'b000100, rv, rpc);
        chk("R9", "entry bank", sp_active, 64'hAAAA);
        set_state(32'h0);
        chk("R9", "bank0 kept", sp_active, 64'h5555);

        // R10: base write at level 0 ignored
        wr_reg(2'd0, 64'hFFFF_0000);
        take(6'b000100, rv, rpc);
        chk("R10", "base kept", rpc, BASE_EXP + 64'h580);

        // R11: request held through ENTER is taken once
        set_state(32'h0);
        drive(6'b000100);
        @(negedge clk);
        chk("R11", "held first", redirect_valid, 1);
        @(negedge clk);
        chk("R11", "held not retaken", redirect_valid, 0);
        drive(6'b0);
        @(negedge clk);
        chk("R11", "held idle", redirect_valid, 0);
        chk("R11", "held state", state_o, 32'hC5);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule